// File: doc/BRIEF.md
# Multicycle Serial Shifter

This block is the shift engine of a small multicycle processor core. It takes a 16-bit operand and moves it one bit position per clock until the requested amount is used up. It supports four operations: logical left, logical right, arithmetic right and rotate left. When it finishes, it presents the result, the carry-out and the number of cycles the operation occupied. The control state machine that issues instructions can use that count to sequence operations whose latency depends on the amount.

The shift amount comes from one of two sources. It is either a 3-bit immediate code or a 4-bit register value. The immediate code covers 1 to 8 positions, so a rotate by 8 swaps the two bytes of the word in a single instruction.

Work enters on a valid/ready handshake. A request transfers on a clock edge where both `in_valid` and `in_ready` are high. While an operation is in flight, `in_ready` stays low and `in_valid` is ignored. The result side has no back-pressure: `out_valid` is a one-cycle pulse and the consumer must take the result in that cycle. `in_ready` is high again in the result cycle, so a new request can transfer in the same cycle that the previous result is delivered.

Top module: `mc_shift_unit`

## Requirements
- R1: During and after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_imm`=1, the amount n is taken from `in_amt[2:0]`. Codes 1 to 7 mean n equals the code, code 0 means n = 8, and `in_amt[3]` is ignored.
- R3: With `in_imm`=0, n is the unsigned value of `in_amt[3:0]` (0 to 15), used directly without any increment.
- R4: Operation code 2'b00 is a logical left shift by n with zero fill. `out_carry` is the last bit shifted out of bit 15.
- R5: Operation code 2'b01 is a logical right shift by n with zero fill. `out_carry` is the last bit shifted out of bit 0.
- R6: Operation code 2'b10 is an arithmetic right shift by n that replicates bit 15. `out_carry` is the last bit shifted out of bit 0.
- R7: Operation code 2'b11 rotates left by n. `out_carry` is the last bit that wrapped from bit 15 into bit 0. A rotate by 8 swaps the high and low bytes.
- R8: For n ≥ 1, if a request transfers in cycle k, then `in_ready` is low in cycles k+1 to k+n. `out_valid` is high for exactly one cycle, k+n+1, and is low in the cycles before it.
- R9: For n = 0, the result appears in cycle k+1 with `out_data` equal to the operand and `out_carry` = 0, and `in_ready` stays high.
- R10: A request presented while `in_ready` is low is ignored. It changes neither the result nor the timing of the operation in flight.
- R11: With `out_valid`, `out_cycles` equals n+1, the number of cycles from the transfer cycle to the result cycle.
- R12: `in_ready` is high in every result cycle. A request that transfers in that cycle is processed normally, back to back with the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_data | input | 16 | Operand |
| in_amt | input | 4 | Register amount, or immediate code in bits 2:0 |
| in_imm | input | 1 | 1 selects the immediate decode of `in_amt` |
| in_op | input | 2 | 00 shift left, 01 logical right, 10 arithmetic right, 11 rotate left |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Shifted result |
| out_carry | output | 1 | Last bit moved out or wrapped |
| out_cycles | output | 5 | Cycles used by the finished operation |

## Verification
Two events can fall in the same cycle: delivering a result and accepting the next request. When this happens, the unit has to end one operation and load another on the same edge. The bench provokes the overlap by holding the next request valid through the busy period, so that it transfers in the result cycle. Zero-amount requests placed back to back go further and produce a result in every cycle. A behavioural model keeps a queue of expected completions with their due cycles. It checks each clock that the pulse, the ready level and the data match, which also catches a request that was taken early while the unit was still busy.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SH_SLL = 2'b00,
    SH_SRL = 2'b01,
    SH_SRA = 2'b10,
    SH_ROL = 2'b11
  } shf_op_e;
endpackage

// File: rtl/shf_amt_decode.sv
// Turns the raw amount field into a step count.
module shf_amt_decode #(
  parameter int AMT_W = 4,
  parameter int IMM_W = 3,
  parameter int CNT_W = AMT_W + 1
) (
  input  logic [AMT_W-1:0] amt_raw,
  input  logic             use_imm,
  output logic [CNT_W-1:0] amt
);
  localparam logic [CNT_W-1:0] IMM_WRAP = CNT_W'(1 << IMM_W);

  logic [IMM_W-1:0] code;
  assign code = amt_raw[IMM_W-1:0];

  always_comb begin
    if (use_imm) begin
      amt = (code == '0) ? IMM_WRAP : CNT_W'(code);
    end else begin
      amt = CNT_W'(amt_raw);
    end
  end
endmodule

// File: rtl/shf_step.sv
// One-position shift of the word, per bit, selected by operation.
module shf_step
  import shf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] d,
  input  shf_op_e           op,
  output logic [DATA_W-1:0] q,
  output logic              out_bit
);
  logic right;
  logic fill_r;
  assign right  = (op == SH_SRL) || (op == SH_SRA);
  assign fill_r = (op == SH_SRA) ? d[DATA_W-1] : 1'b0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic from_left;
    logic from_right;
    if (i == 0) begin : g_lsb
      assign from_left = (op == SH_ROL) ? d[DATA_W-1] : 1'b0;
    end else begin : g_mid_l
      assign from_left = d[i-1];
    end
    if (i == DATA_W - 1) begin : g_msb
      assign from_right = fill_r;
    end else begin : g_mid_r
      assign from_right = d[i+1];
    end
    assign q[i] = right ? from_right : from_left;
  end

  assign out_bit = right ? d[0] : d[DATA_W-1];
endmodule

// File: rtl/shf_ctrl.sv
// Sequencing: counts remaining positions and raises the done strobe.
module shf_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] amt,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cycles
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      left   <= '0;
      cycles <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        cycles <= amt + CNT_W'(1);
        if (amt == '0) begin
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          left <= amt;
        end
      end else if (busy) begin
        left <= left - CNT_W'(1);
        if (left == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mc_shift_unit.sv
module mc_shift_unit
  import shf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 4,
  parameter int IMM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AMT_W-1:0]  in_amt,
  input  logic              in_imm,
  input  logic [1:0]        in_op,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_carry,
  output logic [AMT_W:0]    out_cycles
);
  localparam int CNT_W = AMT_W + 1;

  logic              busy;
  logic              accept;
  logic [CNT_W-1:0]  amt;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] step_q;
  logic              carry_q;
  logic              step_bit;
  shf_op_e           op_q;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  shf_amt_decode #(.AMT_W(AMT_W), .IMM_W(IMM_W), .CNT_W(CNT_W)) u_dec (
    .amt_raw (in_amt),
    .use_imm (in_imm),
    .amt     (amt)
  );

  shf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .amt    (amt),
    .busy   (busy),
    .done   (out_valid),
    .cycles (out_cycles)
  );

  shf_step #(.DATA_W(DATA_W)) u_step (
    .d       (data_q),
    .op      (op_q),
    .q       (step_q),
    .out_bit (step_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      carry_q <= 1'b0;
      op_q    <= SH_SLL;
    end else if (accept) begin
      data_q  <= in_data;
      carry_q <= 1'b0;
      op_q    <= shf_op_e'(in_op);
    end else if (busy) begin
      data_q  <= step_q;
      carry_q <= step_bit;
    end
  end

  assign out_data  = data_q;
  assign out_carry = carry_q;
endmodule

// File: rtl/shf_chk.sv
module shf_chk #(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [AMT_W-1:0]  in_amt,
  input logic              in_imm,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_carry,
  input logic [AMT_W:0]    out_cycles
);
  logic take;
  assign take = in_valid && in_ready;

  assert_take_then_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_valid == in_ready));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !take) |=> !out_valid);

  assert_ready_at_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  assert_zero_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_imm && in_amt == '0) |=>
      (out_valid && !out_carry && out_data == $past(in_data)));

  assert_imm_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_imm && in_amt[2:0] == 3'd1) |=> (!in_ready ##1 out_valid));

  assert_cycles_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cycles != '0 && int'(out_cycles) <= (1 << AMT_W)));
endmodule

bind mc_shift_unit shf_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (.*);

// File: tb/sim_mc_shift_unit.sv
`timescale 1ns/1ps
module sim_mc_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [3:0]  in_amt = '0;
  logic        in_imm = 1'b0;
  logic [1:0]  in_op = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_carry;
  logic [4:0]  out_cycles;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string cur_tag = "R3";
  logic done_flag = 1'b0;

  always #2 clk = ~clk;

  mc_shift_unit u0 (.*);

  typedef struct {
    int          due;
    logic [15:0] d;
    logic        c;
    int          ncyc;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Expected result from the requirements (R2..R7)
  function automatic exp_t predict(input logic [1:0] op, input logic [3:0] amt,
                                   input logic imm, input logic [15:0] d);
    exp_t e;
    int n;
    logic [15:0] v;
    logic c;
    n = imm ? ((amt[2:0] == 3'd0) ? 8 : int'(amt[2:0])) : int'(amt);
    v = d;
    c = 1'b0;
    for (int i = 0; i < n; i++) begin
      case (op)
        2'b00: begin c = v[15]; v = v << 1; end
        2'b01: begin c = v[0];  v = v >> 1; end
        2'b10: begin c = v[0];  v = {v[15], v[15:1]}; end
        default: begin c = v[15]; v = {v[14:0], v[15]}; end
      endcase
    end
    e.d = v;
    e.c = c;
    e.ncyc = n + 1;
    e.due = n;
    e.tag = "";
    return e;
  endfunction

  // Reference model: tracks transfers and due cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
    end else begin
      logic r;
      r = (q.size() == 0) || (q[0].due == cyc);
      if (q.size() > 0 && q[0].due == cyc) void'(q.pop_front());
      if (in_valid && r) begin
        exp_t e;
        e = predict(in_op, in_amt, in_imm, in_data);
        e.due = cyc + 1 + e.due;
        e.tag = cur_tag;
        q.push_back(e);
      end
    end
    cyc = cyc + 1;
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      logic ev;
      logic er;
      ev = (q.size() > 0) && (q[0].due == cyc);
      er = (q.size() == 0) || ev;
      chk("R8", "out_valid", out_valid, ev);
      chk("R8", "in_ready", in_ready, er);
      if (ev) begin
        chk(q[0].tag, "out_data", out_data, q[0].d);
        chk(q[0].tag, "out_carry", out_carry, q[0].c);
        chk("R11", "out_cycles", out_cycles, q[0].ncyc);
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [3:0] amt, input logic imm,
                       input logic [15:0] d, input string tag);
    logic r;
    in_op = op; in_amt = amt; in_imm = imm; in_data = d; in_valid = 1'b1; cur_tag = tag;
    forever begin
      #1 r = in_ready;
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid in reset", out_valid, 0);
    chk("R1", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "in_ready after reset", in_ready, 1);

    issue(2'b00, 4'd3, 1'b1, 16'hA5C3, "R4"); drain();
    issue(2'b01, 4'd5, 1'b0, 16'h8F01, "R5"); drain();
    issue(2'b10, 4'd15, 1'b0, 16'h9234, "R6"); drain();
    issue(2'b10, 4'd4, 1'b0, 16'h7F00, "R6"); drain();
    issue(2'b11, 4'd0, 1'b1, 16'h12AB, "R7"); drain();   // byte swap
    issue(2'b11, 4'd5, 1'b0, 16'h8001, "R7"); drain();
    issue(2'b00, 4'd1, 1'b1, 16'hC000, "R2"); drain();   // shift by one
    issue(2'b01, 4'd10, 1'b1, 16'hFFFF, "R2"); drain();  // bit 3 ignored -> 2
    issue(2'b00, 4'd8, 1'b0, 16'h0181, "R3"); drain();
    issue(2'b01, 4'd0, 1'b0, 16'hBEEF, "R9"); drain();
    issue(2'b00, 4'd0, 1'b0, 16'h1234, "R9");
    issue(2'b11, 4'd0, 1'b0, 16'h5678, "R9"); drain();

    // R10: requests during busy are ignored
    issue(2'b11, 4'd6, 1'b0, 16'h0F0F, "R10");
    in_data = 16'hFFFF; in_op = 2'b10; in_amt = 4'd0; in_imm = 1'b0; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    drain();

    // R12: back-to-back transfers in the result cycle
    issue(2'b00, 4'd2, 1'b0, 16'h1111, "R12");
    issue(2'b01, 4'd3, 1'b1, 16'h8888, "R12");
    issue(2'b10, 4'd0, 1'b0, 16'h8001, "R12");
    issue(2'b11, 4'd1, 1'b0, 16'h8000, "R12");
    drain();

    for (int i = 0; i < 80; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      issue(rv[1:0], rv[5:2], rv[6], rv[31:16], "R3");
      if (rv[7]) drain();
    end
    drain();
    finish_run();
  end
endmodule